// File: doc/BRIEF.md
# Logic Chip Functional Test Sequencer

This block runs a functional test on a socketed 14-pin logic chip. A select input picks one of six device types, and a start pulse begins the test. The block turns each of the twelve signal pins into a driven pin or a sensed pin for the chosen type. It applies a fixed sequence of input patterns and holds each pattern for a programmable settle time. It then samples the chip's outputs and compares them with truth-table values.

The two supply pins are neither driven nor sensed. Combinational parts are tested one gate at a time, over every input combination. The flip-flop part is clocked several times from the block, and both of its outputs are checked after every rising edge.

Each failing case produces a one-cycle fault report. The report carries the gate index, the applied inputs and the observed output. Failing output pins and failing gates are collected in sticky masks. When the sequence ends, a done pulse marks the moment the pass and fail flags become valid. Those flags then hold until the next test starts.

Top module: `chip_test_seq`

## Requirements
- R1: Device code 0 selects quad NAND, 1 selects quad NOR, 2 selects hex inverter, 3 selects quad AND, 4 selects quad OR and 5 selects dual D flip-flop. A start with code 6 or 7 is ignored: the block stays idle, the pins stay released and the previous verdict is kept.
- R2: Pin bus bit i maps to package pin 8+i for i = 0..5, and to package pin i-5 for i = 6..11.
  - The direction mask is loaded when a test starts. It has a 1 exactly on the chip input pins of the selected type: 0x6F6 for NAND, AND and OR, 0xD9B for NOR, 0x56A for the inverter and 0x3FC for the flip-flop.
  - The mask stays constant during the test.
  - When the block is idle, all pins are released and driven low.
- R3: Gates of a combinational type are tested in ascending gate order. Each gate is stepped through its inputs in binary order (00, 01, 10, 11 for two-input gates; 0, 1 for the inverter). All other input pins are driven low.
  - Gate pins (input A, input B, output) are:
    - NAND, AND and OR: (1,2,3), (4,5,6), (9,10,8), (12,13,11).
    - NOR: (2,3,1), (5,6,4), (8,9,10), (11,12,13).
    - Inverter (input, output): (1,2), (3,4), (5,6), (9,8), (11,10), (13,12).
- R4: Each applied pattern is held for S+1 clock cycles before it is sampled, where S is the settle value captured at start. A full test therefore takes 16(S+1) cycles for the two-input types and the flip-flop, and 12(S+1) cycles for the inverter. This time is counted from the start edge to the edge after which done is high.
- R5: For the flip-flop type, the clear inputs (pins 1 and 13) and the preset inputs (pins 4 and 10) are held high.
  - Flip-flop 0 is tested first and flip-flop 1 second. The data, clock, Q and inverted-Q pins are 2, 3, 5, 6 for flip-flop 0 and 12, 11, 9, 8 for flip-flop 1.
  - Each flip-flop receives four rising clock edges with data 1, 0, 1, 0. The data is set while the clock is low, the clock is then raised, and after each edge Q must equal the data and inverted Q its complement.
- R6: The fail pin mask bit of every checked output pin that differs from its expected value is set, and stays set until the next start. Only the outputs of the gate under test are checked.
- R7: A failing case raises the fault-valid output for one cycle with a 6-bit fault code {gate[2:0], a, b, observed}. The fault code is the last failing case's value and holds until a new fault.
  - Two-input gates: a and b are the applied inputs.
  - Inverter: a is 0 and b is the applied input.
  - Flip-flop: gate is the flip-flop index, a is the clocked data, b is 1 and observed is the Q pin.
- R8: Bit g of the gate fail mask is set when any case of gate g (or flip-flop g) fails.
- R9: A valid start clears all results (pass, fail, pin mask, gate mask).
  - After the last sample, done pulses for exactly one cycle. At that point exactly one of pass and fail is set: pass only if no case failed.
  - Pass and fail hold until the next start.
- R10: A start pulse while a test is running has no effect on the running test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a test (one-cycle pulse) |
| dev_sel_i | input | 3 | Device type code |
| settle_i | input | SETTLE_W | Extra settle cycles per pattern |
| pin_sense_i | input | 12 | Sensed chip pin levels |
| pin_oe_o | output | 12 | Direction mask, 1 = block drives the pin |
| pin_drv_o | output | 12 | Drive levels for driven pins |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | One-cycle end-of-test pulse |
| pass_o | output | 1 | All cases passed |
| fail_o | output | 1 | At least one case failed |
| pin_fail_o | output | 12 | Sticky mask of failing output pins |
| gate_fail_o | output | 6 | Sticky mask of failing gates |
| fault_vld_o | output | 1 | One-cycle pulse per failing case |
| fault_code_o | output | 6 | Fault code of the last failing case |

## Verification
The in-line assertions watch, on every cycle, the following properties:
- pins are released while the block is idle;
- no pin is driven outside the direction mask;
- the mask is stable during a test;
- failing pins are always output pins;
- the selected device does not change under a late start;
- done is a single-cycle pulse that carries exactly one verdict.

Only the bench scenarios can show that the pin maps, pattern order, flip-flop edge sequence and settle timing are right. The bench does this with a behavioural chip model, stuck-output faults on every gate at both levels, and a slow-sensing socket. These scenarios establish the expected fault counts, the exact fault codes and the test durations.

// File: rtl/chip_test_pkg.sv
`timescale 1ns/1ps
package chip_test_pkg;
  localparam int NPIN  = 12;
  localparam int IDX_W = 4;
  localparam int FC_W  = 6;
  localparam int NGATE = 6;

  typedef enum logic [2:0] {
    DEV_NAND = 3'd0, DEV_NOR = 3'd1, DEV_INV = 3'd2,
    DEV_AND  = 3'd3, DEV_OR  = 3'd4, DEV_DFF = 3'd5
  } dev_e;

  typedef struct packed {logic [3:0] a; logic [3:0] b; logic [3:0] y;} gpin_t;
  typedef struct packed {logic [3:0] d; logic [3:0] clk; logic [3:0] clr;
                         logic [3:0] pre; logic [3:0] q; logic [3:0] qn;} ffpin_t;

  // package pin number -> pin bus bit
  function automatic logic [3:0] bus_idx(logic [3:0] p);
    return (p >= 4'd8) ? p - 4'd8 : p + 4'd5;
  endfunction

  function automatic logic dev_valid(logic [2:0] d);
    return d <= 3'd5;
  endfunction

  function automatic logic [2:0] n_gates(dev_e d);
    case (d)
      DEV_INV: return 3'd6;
      DEV_DFF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] last_case(dev_e d);
    case (d)
      DEV_INV: return 4'd11;
      DEV_DFF: return 4'd7;
      default: return 4'd15;
    endcase
  endfunction

  function automatic gpin_t gate_pins(dev_e d, logic [2:0] g);
    gpin_t p;
    case (d)
      DEV_NOR: case (g)
        3'd0:    p = '{a: 4'd2,  b: 4'd3,  y: 4'd1};
        3'd1:    p = '{a: 4'd5,  b: 4'd6,  y: 4'd4};
        3'd2:    p = '{a: 4'd8,  b: 4'd9,  y: 4'd10};
        default: p = '{a: 4'd11, b: 4'd12, y: 4'd13};
      endcase
      DEV_INV: case (g)
        3'd0:    p = '{a: 4'd1,  b: 4'd0, y: 4'd2};
        3'd1:    p = '{a: 4'd3,  b: 4'd0, y: 4'd4};
        3'd2:    p = '{a: 4'd5,  b: 4'd0, y: 4'd6};
        3'd3:    p = '{a: 4'd9,  b: 4'd0, y: 4'd8};
        3'd4:    p = '{a: 4'd11, b: 4'd0, y: 4'd10};
        default: p = '{a: 4'd13, b: 4'd0, y: 4'd12};
      endcase
      default: case (g)
        3'd0:    p = '{a: 4'd1,  b: 4'd2,  y: 4'd3};
        3'd1:    p = '{a: 4'd4,  b: 4'd5,  y: 4'd6};
        3'd2:    p = '{a: 4'd9,  b: 4'd10, y: 4'd8};
        default: p = '{a: 4'd12, b: 4'd13, y: 4'd11};
      endcase
    endcase
    return p;
  endfunction

  function automatic ffpin_t ff_pins(logic f);
    if (!f) return '{d: 4'd2,  clk: 4'd3,  clr: 4'd1,  pre: 4'd4,  q: 4'd5, qn: 4'd6};
    else    return '{d: 4'd12, clk: 4'd11, clr: 4'd13, pre: 4'd10, q: 4'd9, qn: 4'd8};
  endfunction

  function automatic logic [NPIN-1:0] dir_mask(dev_e d);
    logic [NPIN-1:0] m;
    gpin_t  gp;
    ffpin_t fp;
    m = '0;
    if (d == DEV_DFF) begin
      for (int f = 0; f < 2; f++) begin
        fp = ff_pins(1'(f));
        m[bus_idx(fp.d)]   = 1'b1;
        m[bus_idx(fp.clk)] = 1'b1;
        m[bus_idx(fp.clr)] = 1'b1;
        m[bus_idx(fp.pre)] = 1'b1;
      end
    end else begin
      for (int g = 0; g < NGATE; g++) begin
        if (3'(g) < n_gates(d)) begin
          gp = gate_pins(d, 3'(g));
          m[bus_idx(gp.a)] = 1'b1;
          if (d != DEV_INV) m[bus_idx(gp.b)] = 1'b1;
        end
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/chip_vec_gen.sv
`timescale 1ns/1ps
module chip_vec_gen
  import chip_test_pkg::*;
(
  input  dev_e             dev_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             phase_i,
  output logic [NPIN-1:0]  drv_o,
  output logic [NPIN-1:0]  chk_o,
  output logic [NPIN-1:0]  exp_o,
  output logic [2:0]       gate_o,
  output logic             ap_o,
  output logic             bp_o,
  output logic [3:0]       obs_o,
  output logic             two_phase_o,
  output logic             last_o
);
  always_comb begin
    gpin_t  gp;
    ffpin_t fp;
    logic   y;
    gp = '0; fp = '0; y = 1'b0;
    drv_o = '0; chk_o = '0; exp_o = '0;
    gate_o = '0; ap_o = 1'b0; bp_o = 1'b0; obs_o = '0; two_phase_o = 1'b0;
    if (dev_i == DEV_DFF) begin
      two_phase_o = 1'b1;
      gate_o = {2'b00, idx_i[2]};
      ap_o   = ~idx_i[0];  // data 1,0,1,0
      bp_o   = 1'b1;
      for (int f = 0; f < 2; f++) begin
        fp = ff_pins(1'(f));
        drv_o[bus_idx(fp.clr)] = 1'b1;
        drv_o[bus_idx(fp.pre)] = 1'b1;
      end
      fp = ff_pins(idx_i[2]);
      drv_o[bus_idx(fp.d)]   = ap_o;
      drv_o[bus_idx(fp.clk)] = phase_i;
      chk_o[bus_idx(fp.q)]   = 1'b1;
      chk_o[bus_idx(fp.qn)]  = 1'b1;
      exp_o[bus_idx(fp.q)]   = ap_o;
      exp_o[bus_idx(fp.qn)]  = ~ap_o;
      obs_o = bus_idx(fp.q);
    end else begin
      if (dev_i == DEV_INV) begin
        gate_o = idx_i[3:1];
        bp_o   = idx_i[0];
        y      = ~bp_o;
      end else begin
        gate_o = {1'b0, idx_i[3:2]};
        ap_o   = idx_i[1];
        bp_o   = idx_i[0];
        case (dev_i)
          DEV_NAND: y = ~(ap_o & bp_o);
          DEV_NOR:  y = ~(ap_o | bp_o);
          DEV_AND:  y = ap_o & bp_o;
          default:  y = ap_o | bp_o;
        endcase
      end
      gp = gate_pins(dev_i, gate_o);
      if (dev_i == DEV_INV) drv_o[bus_idx(gp.a)] = bp_o;
      else begin
        drv_o[bus_idx(gp.a)] = ap_o;
        drv_o[bus_idx(gp.b)] = bp_o;
      end
      chk_o[bus_idx(gp.y)] = 1'b1;
      exp_o[bus_idx(gp.y)] = y;
      obs_o = bus_idx(gp.y);
    end
    last_o = (idx_i == last_case(dev_i));
  end
endmodule

// File: rtl/chip_test_ctrl.sv
`timescale 1ns/1ps
module chip_test_ctrl
  import chip_test_pkg::*;
#(
  parameter int SETTLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [2:0]          dev_sel_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic                two_phase_i,
  input  logic                last_i,
  output dev_e                dev_o,
  output logic [IDX_W-1:0]    idx_o,
  output logic                phase_o,
  output logic [NPIN-1:0]     dir_o,
  output logic                busy_o,
  output logic                sample_o,
  output logic                clr_o,
  output logic                done_o
);
  logic [SETTLE_W-1:0] cnt_q, settle_q;

  assign clr_o    = !busy_o && start_i && dev_valid(dev_sel_i);
  assign sample_o = busy_o && (cnt_q == '0) && (!two_phase_i || phase_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0; dev_o <= DEV_NAND; idx_o <= '0; phase_o <= 1'b0;
      cnt_q <= '0; settle_q <= '0; dir_o <= '0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (clr_o) begin
          busy_o   <= 1'b1;
          dev_o    <= dev_e'(dev_sel_i);
          dir_o    <= dir_mask(dev_e'(dev_sel_i));
          idx_o    <= '0;
          phase_o  <= 1'b0;
          cnt_q    <= settle_i;
          settle_q <= settle_i;
        end
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (two_phase_i && !phase_o) begin
        phase_o <= 1'b1;  // raise clock pin
        cnt_q   <= settle_q;
      end else if (last_i) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
        dir_o  <= '0;
      end else begin
        idx_o   <= idx_o + 1'b1;
        phase_o <= 1'b0;
        cnt_q   <= settle_q;
      end
    end
  end

  a_r10_dev_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(dev_o));
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r2_dir_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(dir_o));
endmodule

// File: rtl/chip_test_result.sv
`timescale 1ns/1ps
module chip_test_result
  import chip_test_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             sample_i,
  input  logic             last_i,
  input  logic [NPIN-1:0]  sense_i,
  input  logic [NPIN-1:0]  chk_i,
  input  logic [NPIN-1:0]  exp_i,
  input  logic [2:0]       gate_i,
  input  logic             ap_i,
  input  logic             bp_i,
  input  logic [3:0]       obs_i,
  output logic [NPIN-1:0]  pin_fail_o,
  output logic [NGATE-1:0] gate_fail_o,
  output logic             fault_vld_o,
  output logic [FC_W-1:0]  fault_code_o,
  output logic             pass_o,
  output logic             fail_o
);
  logic [NPIN-1:0] mism;
  logic            any_q, hit;

  assign mism = (sense_i ^ exp_i) & chk_i;
  assign hit  = sample_i && (mism != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_fail_o <= '0; gate_fail_o <= '0; fault_vld_o <= 1'b0;
      fault_code_o <= '0; pass_o <= 1'b0; fail_o <= 1'b0; any_q <= 1'b0;
    end else begin
      fault_vld_o <= hit;
      if (clr_i) begin
        pin_fail_o <= '0; gate_fail_o <= '0; any_q <= 1'b0;
        pass_o <= 1'b0; fail_o <= 1'b0;
      end else if (sample_i) begin
        pin_fail_o <= pin_fail_o | mism;
        if (hit) begin
          gate_fail_o[gate_i] <= 1'b1;
          fault_code_o <= {gate_i, ap_i, bp_i, sense_i[obs_i]};
          any_q <= 1'b1;
        end
        if (last_i) begin
          pass_o <= !(any_q || hit);
          fail_o <= any_q || hit;
        end
      end
    end
  end

  a_r9_verdict_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && fail_o));
  a_r8_fault_marks_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_vld_o |-> gate_fail_o != '0 && pin_fail_o != '0);
endmodule

// File: rtl/chip_test_seq.sv
`timescale 1ns/1ps
module chip_test_seq
  import chip_test_pkg::*;
#(
  parameter int SETTLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [2:0]          dev_sel_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic [11:0]         pin_sense_i,
  output logic [11:0]         pin_oe_o,
  output logic [11:0]         pin_drv_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                pass_o,
  output logic                fail_o,
  output logic [11:0]         pin_fail_o,
  output logic [5:0]          gate_fail_o,
  output logic                fault_vld_o,
  output logic [5:0]          fault_code_o
);
  dev_e             dev;
  logic [IDX_W-1:0] idx;
  logic             phase, two_phase, last, sample, clr;
  logic [NPIN-1:0]  drv, chk, expv;
  logic [2:0]       gate;
  logic             ap, bp;
  logic [3:0]       obs;

  chip_test_ctrl #(.SETTLE_W(SETTLE_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .dev_sel_i, .settle_i,
    .two_phase_i(two_phase), .last_i(last),
    .dev_o(dev), .idx_o(idx), .phase_o(phase), .dir_o(pin_oe_o),
    .busy_o, .sample_o(sample), .clr_o(clr), .done_o
  );

  chip_vec_gen u_vec (
    .dev_i(dev), .idx_i(idx), .phase_i(phase),
    .drv_o(drv), .chk_o(chk), .exp_o(expv), .gate_o(gate),
    .ap_o(ap), .bp_o(bp), .obs_o(obs), .two_phase_o(two_phase), .last_o(last)
  );

  chip_test_result u_res (
    .clk_i, .rst_ni, .clr_i(clr), .sample_i(sample), .last_i(last),
    .sense_i(pin_sense_i), .chk_i(chk), .exp_i(expv), .gate_i(gate),
    .ap_i(ap), .bp_i(bp), .obs_i(obs),
    .pin_fail_o, .gate_fail_o, .fault_vld_o, .fault_code_o, .pass_o, .fail_o
  );

  assign pin_drv_o = busy_o ? drv : '0;

  a_r2_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> pin_oe_o == '0 && pin_drv_o == '0);
  a_r2_drive_in_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_drv_o & ~pin_oe_o) == '0);
  a_r6_fail_on_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (pin_fail_o & pin_oe_o) == '0);
  a_r9_verdict_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (pass_o ^ fail_o));
endmodule

// File: tb/tb_chip_test_seq.sv
`timescale 1ns/1ps
module tb_chip_test_seq;
  logic        clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [2:0]  dev_sel_i = '0;
  logic [15:0] settle_i = '0;
  logic [11:0] pin_sense_i;
  logic [11:0] pin_oe_o, pin_drv_o, pin_fail_o;
  logic        busy_o, done_o, pass_o, fail_o, fault_vld_o;
  logic [5:0]  gate_fail_o, fault_code_o;

  chip_test_seq dut (.*);

  always #10 clk_i = ~clk_i;

  int n_run = 0, n_fail = 0;
  int chip = 0;
  logic [11:0] stk_en = '0, stk_val = '0;
  logic use_dly = 1'b0;

  localparam int STD_A[4] = '{1, 4, 9, 12};
  localparam int STD_B[4] = '{2, 5, 10, 13};
  localparam int STD_Y[4] = '{3, 6, 8, 11};
  localparam int NOR_A[4] = '{2, 5, 8, 11};
  localparam int NOR_B[4] = '{3, 6, 9, 12};
  localparam int NOR_Y[4] = '{1, 4, 10, 13};
  localparam int INV_A[6] = '{1, 3, 5, 9, 11, 13};
  localparam int INV_Y[6] = '{2, 4, 6, 8, 10, 12};

  function automatic int bus(int p);
    return (p >= 8) ? p - 8 : p + 5;
  endfunction

  function automatic logic gfun(int d, logic a, logic b);
    case (d)
      0: return ~(a & b);
      1: return ~(a | b);
      3: return a & b;
      default: return a | b;
    endcase
  endfunction

  function automatic logic [11:0] dmask(int d);
    case (d)
      1: return 12'hD9B;
      2: return 12'h56A;
      5: return 12'h3FC;
      default: return 12'h6F6;
    endcase
  endfunction

  // behavioural chip in the socket
  logic q0 = 1'b0, q1 = 1'b0;
  always @(posedge pin_drv_o[8]) q0 <= pin_drv_o[7];
  always @(posedge pin_drv_o[3]) q1 <= pin_drv_o[4];

  logic [11:0] model, raw, d1, d2;
  always_comb begin
    model = '0;
    if (chip == 5) begin
      model[10] = q0; model[11] = ~q0; model[1] = q1; model[0] = ~q1;
    end else if (chip == 2) begin
      for (int g = 0; g < 6; g++) model[bus(INV_Y[g])] = ~pin_drv_o[bus(INV_A[g])];
    end else if (chip == 1) begin
      for (int g = 0; g < 4; g++)
        model[bus(NOR_Y[g])] = gfun(1, pin_drv_o[bus(NOR_A[g])], pin_drv_o[bus(NOR_B[g])]);
    end else begin
      for (int g = 0; g < 4; g++)
        model[bus(STD_Y[g])] = gfun(chip, pin_drv_o[bus(STD_A[g])], pin_drv_o[bus(STD_B[g])]);
    end
  end
  assign raw = (model & ~stk_en) | (stk_val & stk_en);
  always @(posedge clk_i) begin d1 <= raw; d2 <= d1; end
  assign pin_sense_i = use_dly ? d2 : raw;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, expv);
    end
  endtask

  int          cyc, nflt;
  logic [5:0]  fcode;
  logic [11:0] oe_seen;
  bit          cleared;

  task automatic run_dev(input int d, input int s);
    @(negedge clk_i);
    dev_sel_i = 3'(d); settle_i = 16'(s); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    oe_seen = pin_oe_o;
    cleared = (pin_fail_o == '0) && (gate_fail_o == '0) && !pass_o && !fail_o;
    cyc = 0; nflt = 0; fcode = '0;
    while (!done_o && cyc < 5000) begin
      @(posedge clk_i); @(negedge clk_i);
      cyc++;
      if (fault_vld_o) begin
        if (nflt == 0) fcode = fault_code_o;
        nflt++;
      end
    end
  endtask

  initial begin
    #(20 * 190000);
    n_run++; n_fail++;
    $display("FAIL R4 watchdog expired: got 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !pass_o && !fail_o, "R9", "reset state flags",
        {busy_o, done_o, pass_o, fail_o}, 0);
    chk(pin_oe_o == 0 && pin_drv_o == 0, "R2", "reset pins released", {pin_oe_o, pin_drv_o}, 0);
    rst_ni = 1'b1;

    // R3/R6/R7/R8: stuck outputs on every two-input gate
    foreach (STD_A[k]) begin end
    for (int di = 0; di < 4; di++) begin
      int d;
      d = (di < 2) ? di : di + 1;
      for (int g = 0; g < 4; g++) begin
        for (int v = 0; v < 2; v++) begin
          int yb, ne;
          logic [5:0] ec;
          bit found;
          yb = (d == 1) ? bus(NOR_Y[g]) : bus(STD_Y[g]);
          ne = 0; ec = '0; found = 0;
          for (int ab = 0; ab < 4; ab++) begin
            logic a, b;
            a = ab[1]; b = ab[0];
            if (gfun(d, a, b) != v[0]) begin
              ne++;
              if (!found) begin ec = {3'(g), a, b, v[0]}; found = 1; end
            end
          end
          chip = d; stk_en = 12'(1) << yb; stk_val = v[0] ? stk_en : '0;
          run_dev(d, 0);
          chk(fail_o && !pass_o, "R9", "fail verdict on stuck gate", {pass_o, fail_o}, 1);
          chk(pin_fail_o == (12'(1) << yb), "R6", "pin fail mask", pin_fail_o, 12'(1) << yb);
          chk(gate_fail_o == (6'(1) << g), "R8", "gate fail mask", gate_fail_o, 6'(1) << g);
          chk(nflt == ne, "R3", "failing case count", nflt, ne);
          chk(fcode == ec, "R7", "first fault code", fcode, ec);
        end
      end
    end

    // inverter stuck outputs
    for (int g = 0; g < 6; g++) begin
      for (int v = 0; v < 2; v++) begin
        int yb;
        yb = bus(INV_Y[g]);
        chip = 2; stk_en = 12'(1) << yb; stk_val = v[0] ? stk_en : '0;
        run_dev(2, 0);
        chk(pin_fail_o == (12'(1) << yb), "R6", "inverter pin mask", pin_fail_o, 12'(1) << yb);
        chk(gate_fail_o == (6'(1) << g), "R8", "inverter gate mask", gate_fail_o, 6'(1) << g);
        chk(nflt == 1, "R3", "inverter fault count", nflt, 1);
        chk(fcode == {3'(g), 1'b0, v[0], v[0]}, "R7", "inverter fault code",
            fcode, {3'(g), 1'b0, v[0], v[0]});
      end
    end

    // flip-flop stuck Q / inverted Q
    for (int f = 0; f < 2; f++) begin
      for (int w = 0; w < 2; w++) begin
        for (int v = 0; v < 2; v++) begin
          int pb;
          logic [5:0] ec;
          pb = (f == 0) ? ((w == 0) ? 10 : 11) : ((w == 0) ? 1 : 0);
          if (w == 0) ec = v[0] ? {3'(f), 1'b0, 1'b1, 1'b1} : {3'(f), 1'b1, 1'b1, 1'b0};
          else        ec = v[0] ? {3'(f), 1'b1, 1'b1, 1'b1} : {3'(f), 1'b0, 1'b1, 1'b0};
          chip = 5; stk_en = 12'(1) << pb; stk_val = v[0] ? stk_en : '0;
          run_dev(5, 1);
          chk(pin_fail_o == (12'(1) << pb), "R5", "flip-flop pin mask", pin_fail_o, 12'(1) << pb);
          chk(gate_fail_o == (6'(1) << f), "R8", "flip-flop gate mask", gate_fail_o, 6'(1) << f);
          chk(nflt == 2, "R5", "flip-flop fault count", nflt, 2);
          chk(fcode == ec, "R7", "flip-flop fault code", fcode, ec);
        end
      end
    end
    stk_en = '0; stk_val = '0;

    // good chips of every type
    for (int d = 0; d < 6; d++) begin
      int t;
      t = ((d == 2) ? 12 : 16) * 4;
      chip = d;
      run_dev(d, 3);
      chk(cleared, "R9", "results cleared at start", cleared, 1);
      chk(oe_seen == dmask(d), "R2", "direction mask", oe_seen, dmask(d));
      chk(cyc == t, "R4", "test duration", cyc, t);
      chk(pass_o && !fail_o, (d == 5) ? "R5" : "R3", "good chip passes", {pass_o, fail_o}, 2);
      chk(pin_fail_o == 0 && gate_fail_o == 0 && nflt == 0, "R6", "no failing pins",
          {pin_fail_o, gate_fail_o}, 0);
      @(negedge clk_i);
      chk(!done_o && pass_o, "R9", "done single pulse, verdict held", {done_o, pass_o}, 1);
      chk(pin_oe_o == 0 && pin_drv_o == 0, "R2", "pins released after test",
          {pin_oe_o, pin_drv_o}, 0);
    end

    // invalid device codes
    for (int d = 6; d < 8; d++) begin
      @(negedge clk_i); dev_sel_i = 3'(d); start_i = 1'b1;
      @(negedge clk_i); start_i = 1'b0;
      repeat (4) @(negedge clk_i);
      chk(!busy_o && pin_oe_o == 0 && pass_o && !fail_o, "R1", "invalid code ignored",
          {busy_o, pin_oe_o, pass_o, fail_o}, 32'h2);
    end

    // start while running
    chip = 0;
    @(negedge clk_i); dev_sel_i = 3'd0; settle_i = 16'd1; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    cyc = 0;
    repeat (5) begin @(posedge clk_i); @(negedge clk_i); cyc++; end
    dev_sel_i = 3'd2; start_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i); cyc++; start_i = 1'b0;
    chk(pin_oe_o == 12'h6F6, "R10", "mask kept under late start", pin_oe_o, 12'h6F6);
    while (!done_o && cyc < 5000) begin @(posedge clk_i); @(negedge clk_i); cyc++; end
    chk(cyc == 32, "R10", "late start duration", cyc, 32);
    chk(pass_o, "R10", "late start verdict", pass_o, 1);

    // slow-sensing socket: settle time decides the verdict
    use_dly = 1'b1; chip = 0;
    run_dev(0, 2);
    chk(pass_o && !fail_o, "R4", "settle 2 covers 2-cycle sense lag", {pass_o, fail_o}, 2);
    run_dev(0, 0);
    chk(fail_o && !pass_o, "R4", "settle 0 misses 2-cycle sense lag", {pass_o, fail_o}, 1);
    use_dly = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule